// File: doc/BRIEF.md
# Task-Tagged Translation Lookaside Cache

This block is a fully associative cache of page translations. Each of its 64 slots holds a logical page tag, a small task alias, a write-protect bit and a physical page number. A lookup compares the presented logical page and the current task alias against every valid slot at once. It returns a hit with the physical page, a miss, or a write-protect violation for a write that lands on a protected slot. Because every slot carries an alias, translations that belong to several tasks can sit in the cache side by side.

No strobe is needed to start a lookup. The block watches the logical page, alias and write inputs. Whenever any of them differs from the value it last captured, it evaluates the key and registers the outcome on the next clock edge. After a fill or a flush it also re-evaluates the key it is holding, so the outputs never reflect table contents that are out of date. Misses are served by an outside table walker, which presents a new descriptor on the fill port. The block places that descriptor in an empty slot if one exists. Otherwise it places it in the slot named by a pseudo-LRU tree. Two kinds of invalidation are provided: one clears every slot, and the other clears only the slots of a chosen alias.

Top module: `tlb_cam_cache`

## Requirements
- R1: While reset is asserted and right after it, hit_o=0, wprot_viol_o=0, ppn_o=0 and miss_o=1.
- R2: When the lookup key changes before a rising edge and matches a valid slot, hit_o=1 and ppn_o equals that slot's physical page right after that edge.
- R3: A key whose tag matches a slot but whose alias differs, or whose tag matches no valid slot, gives miss_o=1 and hit_o=0. miss_o is never high together with hit_o or wprot_viol_o.
- R4: A write (lk_write_i=1) that matches a slot whose write-protect bit is 1 gives wprot_viol_o=1, hit_o=0 and ppn_o=0. A read of the same slot gives a normal hit.
- R5: A fill made while any slot is empty goes into an empty slot, and no valid translation is lost.
- R6: The replacement choice follows a 63-node pseudo-LRU tree that is touched on every hit caused by a key change and on every fill. After slots 0..63 are filled in order and slot 0 is then hit, the next fill of a full cache evicts slot 32.
- R7: A flush-all pulse makes every key miss. Two edges after the pulse, miss_o=1.
- R8: A flush-by-alias pulse invalidates every slot whose alias equals flush_alias_id_i within one edge and leaves slots of other aliases valid.
- R9: When a fill and a flush occur in the same cycle, the flush acts on the slots as they stood before that cycle, and the freshly filled slot stays valid, even if its alias is the one being flushed.
- R10: After a fill or a flush, the held lookup key is evaluated again without any change of key, so the outputs reflect the new contents two edges after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lk_page_i | input | 20 | Logical page of the lookup key |
| lk_alias_i | input | 3 | Task alias of the lookup key |
| lk_write_i | input | 1 | Lookup is for a write access |
| hit_o | output | 1 | Translation found and access allowed |
| miss_o | output | 1 | No valid slot matches the key |
| wprot_viol_o | output | 1 | Write to a write-protected slot |
| ppn_o | output | 20 | Physical page when hit_o is high, otherwise 0 |
| fill_valid_i | input | 1 | Load a descriptor this cycle |
| fill_page_i | input | 20 | Logical page of the new descriptor |
| fill_alias_i | input | 3 | Task alias of the new descriptor |
| fill_wprot_i | input | 1 | Write-protect bit of the new descriptor |
| fill_ppn_i | input | 20 | Physical page of the new descriptor |
| flush_all_i | input | 1 | Invalidate every slot |
| flush_alias_i | input | 1 | Invalidate the slots of one alias |
| flush_alias_id_i | input | 3 | Alias to invalidate |

## Verification
The case that matters most is a fill and a flush-by-alias that fall in the same cycle, with the new descriptor carrying the very alias being flushed. The bench pulses both strobes on one clock. It then looks up the new page and older pages of that alias. The new page must hit and the older pages must miss. Separately, a held key is flushed without any change of key, to confirm that the refresh path alone brings the outputs up to date.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned TLB_ENTRIES = 64;
  localparam int unsigned TLB_TAG_W   = 20;
  localparam int unsigned TLB_ALIAS_W = 3;
  localparam int unsigned TLB_PPN_W   = 20;

  // outcome of one evaluated lookup
  typedef struct packed {
    logic hit;
    logic miss;
    logic viol;
  } lk_status_t;
endpackage

// File: rtl/tlb_prio_enc.sv
module tlb_prio_enc #(
  parameter int unsigned N     = 64,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     vec_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             found_o
);
  // lowest set bit wins
  always_comb begin
    idx_o   = '0;
    found_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        idx_o   = IDX_W'(i);
        found_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tlb_entry_array.sv
module tlb_entry_array #(
  parameter int unsigned N       = 64,
  parameter int unsigned TAG_W   = 20,
  parameter int unsigned ALIAS_W = 3,
  parameter int unsigned PPN_W   = 20,
  parameter int unsigned IDX_W   = $clog2(N)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [TAG_W-1:0]   wr_tag_i,
  input  logic [ALIAS_W-1:0] wr_alias_i,
  input  logic               wr_wp_i,
  input  logic [PPN_W-1:0]   wr_ppn_i,
  input  logic               flush_all_i,
  input  logic               flush_alias_i,
  input  logic [ALIAS_W-1:0] flush_alias_id_i,
  input  logic [TAG_W-1:0]   lk_tag_i,
  input  logic [ALIAS_W-1:0] lk_alias_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic [N-1:0]       match_o,
  output logic [N-1:0]       valid_o,
  output logic [PPN_W-1:0]   rd_ppn_o,
  output logic               rd_wp_o
);
  logic [N-1:0]       valid_q, valid_d, kill, wr_sel;
  logic [TAG_W-1:0]   tag_q   [N];
  logic [ALIAS_W-1:0] alias_q [N];
  logic [PPN_W-1:0]   ppn_q   [N];
  logic               wp_q    [N];

  // per-slot compare and invalidate decode
  for (genvar g = 0; g < N; g++) begin : g_slot
    assign match_o[g] = valid_q[g] && (tag_q[g] == lk_tag_i) && (alias_q[g] == lk_alias_i);
    assign kill[g]    = flush_all_i || (flush_alias_i && (alias_q[g] == flush_alias_id_i));
    assign wr_sel[g]  = wr_en_i && (wr_idx_i == IDX_W'(g));
  end

  // flush works on pre-cycle contents, fill lands afterwards
  always_comb begin
    valid_d = (valid_q & ~kill) | wr_sel;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else         valid_q <= valid_d;
  end

  // payload carries no reset; valid gates its use
  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx_i]   <= wr_tag_i;
      alias_q[wr_idx_i] <= wr_alias_i;
      ppn_q[wr_idx_i]   <= wr_ppn_i;
      wp_q[wr_idx_i]    <= wr_wp_i;
    end
  end

  assign valid_o  = valid_q;
  assign rd_ppn_o = ppn_q[rd_idx_i];
  assign rd_wp_o  = wp_q[rd_idx_i];
endmodule

// File: rtl/tlb_plru.sv
module tlb_plru #(
  parameter int unsigned N     = 64,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_a_i,
  input  logic [IDX_W-1:0] touch_a_idx_i,
  input  logic             touch_b_i,
  input  logic [IDX_W-1:0] touch_b_idx_i,
  output logic [IDX_W-1:0] victim_o
);
  // node k has children 2k+1 (left) and 2k+2 (right); bit 1 = victim on the right
  logic [N-2:0] tree_q, tree_d;

  function automatic logic [N-2:0] mark_path(input logic [N-2:0] t, input logic [IDX_W-1:0] idx);
    logic [N-2:0] r;
    int unsigned  node;
    r    = t;
    node = 0;
    for (int l = 0; l < int'(IDX_W); l++) begin
      r[node] = ~idx[IDX_W-1-l];
      node    = 2 * node + 1 + 32'(idx[IDX_W-1-l]);
    end
    return r;
  endfunction

  always_comb begin
    tree_d = tree_q;
    if (touch_a_i) tree_d = mark_path(tree_d, touch_a_idx_i);
    if (touch_b_i) tree_d = mark_path(tree_d, touch_b_idx_i);
  end

  always_comb begin
    int unsigned node;
    node     = 0;
    victim_o = '0;
    for (int l = 0; l < int'(IDX_W); l++) begin
      victim_o[IDX_W-1-l] = tree_q[node];
      node = 2 * node + 1 + 32'(tree_q[node]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      tree_q <= '0;
    else if (touch_a_i || touch_b_i)  tree_q <= tree_d;
  end
endmodule

// File: rtl/tlb_cam_cache.sv
module tlb_cam_cache
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = TLB_ENTRIES,
  parameter int unsigned TAG_W   = TLB_TAG_W,
  parameter int unsigned ALIAS_W = TLB_ALIAS_W,
  parameter int unsigned PPN_W   = TLB_PPN_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [TAG_W-1:0]   lk_page_i,
  input  logic [ALIAS_W-1:0] lk_alias_i,
  input  logic               lk_write_i,
  output logic               hit_o,
  output logic               miss_o,
  output logic               wprot_viol_o,
  output logic [PPN_W-1:0]   ppn_o,
  input  logic               fill_valid_i,
  input  logic [TAG_W-1:0]   fill_page_i,
  input  logic [ALIAS_W-1:0] fill_alias_i,
  input  logic               fill_wprot_i,
  input  logic [PPN_W-1:0]   fill_ppn_i,
  input  logic               flush_all_i,
  input  logic               flush_alias_i,
  input  logic [ALIAS_W-1:0] flush_alias_id_i
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] match_vec, valid_q;
  logic [IDX_W-1:0]   hit_idx, free_idx, plru_idx, fill_idx;
  logic               any_match, any_free, rd_wp;
  logic [PPN_W-1:0]   rd_ppn;

  // key tracking and refresh flag
  logic [TAG_W-1:0]   key_page_q;
  logic [ALIAS_W-1:0] key_alias_q;
  logic               key_wr_q, stale_q, stale_d;
  logic               key_change, eval_en, touch_hit;

  lk_status_t st_d, st_q;
  logic [PPN_W-1:0] ppn_d, ppn_q;

  tlb_entry_array #(
    .N(ENTRIES), .TAG_W(TAG_W), .ALIAS_W(ALIAS_W), .PPN_W(PPN_W), .IDX_W(IDX_W)
  ) u_array (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .wr_en_i          (fill_valid_i),
    .wr_idx_i         (fill_idx),
    .wr_tag_i         (fill_page_i),
    .wr_alias_i       (fill_alias_i),
    .wr_wp_i          (fill_wprot_i),
    .wr_ppn_i         (fill_ppn_i),
    .flush_all_i      (flush_all_i),
    .flush_alias_i    (flush_alias_i),
    .flush_alias_id_i (flush_alias_id_i),
    .lk_tag_i         (lk_page_i),
    .lk_alias_i       (lk_alias_i),
    .rd_idx_i         (hit_idx),
    .match_o          (match_vec),
    .valid_o          (valid_q),
    .rd_ppn_o         (rd_ppn),
    .rd_wp_o          (rd_wp)
  );

  tlb_prio_enc #(.N(ENTRIES), .IDX_W(IDX_W)) u_hit_enc (
    .vec_i   (match_vec),
    .idx_o   (hit_idx),
    .found_o (any_match)
  );

  tlb_prio_enc #(.N(ENTRIES), .IDX_W(IDX_W)) u_free_enc (
    .vec_i   (~valid_q),
    .idx_o   (free_idx),
    .found_o (any_free)
  );

  tlb_plru #(.N(ENTRIES), .IDX_W(IDX_W)) u_plru (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .touch_a_i     (touch_hit),
    .touch_a_idx_i (hit_idx),
    .touch_b_i     (fill_valid_i),
    .touch_b_idx_i (fill_idx),
    .victim_o      (plru_idx)
  );

  // empty slots are always used before evicting
  assign fill_idx = any_free ? free_idx : plru_idx;

  assign key_change = (lk_page_i != key_page_q) || (lk_alias_i != key_alias_q) ||
                      (lk_write_i != key_wr_q);
  assign eval_en    = key_change || stale_q;
  assign stale_d    = fill_valid_i || flush_all_i || flush_alias_i;

  always_comb begin
    st_d.viol = any_match && lk_write_i && rd_wp;
    st_d.hit  = any_match && !st_d.viol;
    st_d.miss = !any_match;
    ppn_d     = st_d.hit ? rd_ppn : '0;
  end

  // only fresh keys age the tree; refreshes do not
  assign touch_hit = key_change && st_d.hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_page_q  <= '0;
      key_alias_q <= '0;
      key_wr_q    <= 1'b0;
      stale_q     <= 1'b1;
    end else begin
      key_page_q  <= lk_page_i;
      key_alias_q <= lk_alias_i;
      key_wr_q    <= lk_write_i;
      stale_q     <= stale_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= '{hit: 1'b0, miss: 1'b1, viol: 1'b0};
      ppn_q <= '0;
    end else if (eval_en) begin
      st_q  <= st_d;
      ppn_q <= ppn_d;
    end
  end

  assign hit_o        = st_q.hit;
  assign miss_o       = st_q.miss;
  assign wprot_viol_o = st_q.viol;
  assign ppn_o        = ppn_q;
endmodule

// File: rtl/tlb_cam_cache_chk.sv
module tlb_cam_cache_chk #(
  parameter int unsigned N     = 64,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hit_o,
  input logic             miss_o,
  input logic             wprot_viol_o,
  input logic             fill_valid_i,
  input logic             flush_all_i,
  input logic             flush_alias_i,
  input logic [N-1:0]     valid_q,
  input logic [IDX_W-1:0] fill_idx
);
  // R4
  viol_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && wprot_viol_o));

  // R3
  miss_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> !(hit_o || wprot_viol_o));

  // R7
  flush_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_all_i && !fill_valid_i) |=> ##1 miss_o);

  // R5
  free_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && !(&valid_q)) |-> !valid_q[fill_idx]);

  // R6
  full_stays_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && (&valid_q) && !flush_all_i && !flush_alias_i) |=> (&valid_q));
endmodule

bind tlb_cam_cache tlb_cam_cache_chk #(.N(ENTRIES), .IDX_W(IDX_W)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .hit_o         (hit_o),
  .miss_o        (miss_o),
  .wprot_viol_o  (wprot_viol_o),
  .fill_valid_i  (fill_valid_i),
  .flush_all_i   (flush_all_i),
  .flush_alias_i (flush_alias_i),
  .valid_q       (valid_q),
  .fill_idx      (fill_idx)
);

// File: tb/tlb_cam_cache_tb_top.sv
module tlb_cam_cache_tb_top;
  logic        clk, rst_n;
  logic [19:0] lk_page;
  logic [2:0]  lk_alias;
  logic        lk_write;
  logic        hit, miss, viol;
  logic [19:0] ppn;
  logic        fill_v;
  logic [19:0] fill_page;
  logic [2:0]  fill_alias;
  logic        fill_wp;
  logic [19:0] fill_ppn;
  logic        fl_all, fl_al;
  logic [2:0]  fl_id;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  tlb_cam_cache dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_page_i(lk_page), .lk_alias_i(lk_alias), .lk_write_i(lk_write),
    .hit_o(hit), .miss_o(miss), .wprot_viol_o(viol), .ppn_o(ppn),
    .fill_valid_i(fill_v), .fill_page_i(fill_page), .fill_alias_i(fill_alias),
    .fill_wprot_i(fill_wp), .fill_ppn_i(fill_ppn),
    .flush_all_i(fl_all), .flush_alias_i(fl_al), .flush_alias_id_i(fl_id)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [19:0] xlat(input logic [19:0] p);
    return p ^ 20'hA5A5A;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_fill(input logic [19:0] p, input logic [2:0] a, input logic wp);
    @(negedge clk);
    fill_v = 1; fill_page = p; fill_alias = a; fill_wp = wp; fill_ppn = xlat(p);
    @(negedge clk);
    fill_v = 0;
    @(negedge clk);
  endtask

  task automatic do_flush(input bit all, input logic [2:0] id);
    @(negedge clk);
    fl_all = all; fl_al = !all; fl_id = id;
    @(negedge clk);
    fl_all = 0; fl_al = 0;
    @(negedge clk);
  endtask

  task automatic look(input logic [19:0] p, input logic [2:0] a, input logic w);
    @(negedge clk);
    lk_page = p; lk_alias = a; lk_write = w;
    @(negedge clk);
  endtask

  task automatic expect_hit(input string req, input logic [19:0] p);
    chk(hit && !miss && !viol, req, {29'd0, hit, miss, viol}, 32'h4);
    chk(ppn == xlat(p), req, {12'd0, ppn}, {12'd0, xlat(p)});
  endtask

  task automatic expect_miss(input string req);
    chk(miss && !hit && !viol, req, {29'd0, hit, miss, viol}, 32'h2);
  endtask

  task automatic t_reset;
    rst_n = 0;
    lk_page = 0; lk_alias = 0; lk_write = 0;
    fill_v = 0; fill_page = 0; fill_alias = 0; fill_wp = 0; fill_ppn = 0;
    fl_all = 0; fl_al = 0; fl_id = 0;
    repeat (3) @(negedge clk);
    chk(!hit && miss && !viol && ppn == 0, "R1 in reset", {9'd0, hit, miss, viol, ppn}, 32'h200000);
    rst_n = 1;
    @(negedge clk);
    chk(!hit && miss && !viol && ppn == 0, "R1 after reset", {9'd0, hit, miss, viol, ppn}, 32'h200000);
  endtask

  task automatic t_basic;
    do_fill(20'h00012, 3'd2, 1'b0);
    look(20'h00012, 3'd2, 1'b0); expect_hit("R2 hit", 20'h00012);
    look(20'h00012, 3'd3, 1'b0); expect_miss("R3 alias mismatch");
    look(20'h00013, 3'd2, 1'b0); expect_miss("R3 tag mismatch");
    look(20'h00012, 3'd2, 1'b1); expect_hit("R2 write unprotected", 20'h00012);
  endtask

  task automatic t_wprot;
    do_fill(20'h00300, 3'd2, 1'b1);
    look(20'h00300, 3'd2, 1'b0); expect_hit("R4 read protected", 20'h00300);
    look(20'h00300, 3'd2, 1'b1);
    chk(viol && !hit && !miss && ppn == 0, "R4 write violation", {9'd0, hit, miss, viol, ppn}, 32'h100000);
  endtask

  task automatic t_fill_plru;
    do_flush(1'b1, 3'd0);
    look(20'hFFFFF, 3'd7, 1'b0);
    for (int k = 0; k < 64; k++) do_fill(20'h00100 + 20'(k), (k == 5) ? 3'd4 : 3'd1, 1'b0);
    look(20'h00100, 3'd1, 1'b0); expect_hit("R6 touch slot 0", 20'h00100);
    do_fill(20'h00900, 3'd1, 1'b0);
    look(20'h00120, 3'd1, 1'b0); expect_miss("R6 slot 32 evicted");
    look(20'h00900, 3'd1, 1'b0); expect_hit("R6 new entry", 20'h00900);
    look(20'h00100, 3'd1, 1'b0); expect_hit("R6 slot 0 kept", 20'h00100);
    do_flush(1'b0, 3'd4);
    look(20'h00105, 3'd4, 1'b0); expect_miss("R8 flushed alias");
    look(20'h00101, 3'd1, 1'b0); expect_hit("R8 other alias kept", 20'h00101);
    do_fill(20'h00A00, 3'd1, 1'b0);
    for (int k = 0; k < 64; k++) begin
      if (k != 5 && k != 32) begin
        look(20'h00100 + 20'(k), 3'd1, 1'b0);
        expect_hit("R5 no valid entry lost", 20'h00100 + 20'(k));
      end
    end
    look(20'h00A00, 3'd1, 1'b0); expect_hit("R5 filled empty slot", 20'h00A00);
    look(20'h00900, 3'd1, 1'b0); expect_hit("R5 entry kept", 20'h00900);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    fl_al = 1; fl_id = 3'd1;
    fill_v = 1; fill_page = 20'h00B00; fill_alias = 3'd1; fill_wp = 0; fill_ppn = xlat(20'h00B00);
    @(negedge clk);
    fl_al = 0; fill_v = 0;
    @(negedge clk);
    look(20'h00B00, 3'd1, 1'b0); expect_hit("R9 fill survives flush", 20'h00B00);
    look(20'h00101, 3'd1, 1'b0); expect_miss("R9 old alias flushed");
    look(20'h00A00, 3'd1, 1'b0); expect_miss("R9 old alias flushed");
  endtask

  task automatic t_refresh;
    look(20'h00B00, 3'd1, 1'b0); expect_hit("R10 before flush", 20'h00B00);
    do_flush(1'b1, 3'd0);
    expect_miss("R10 held key refreshed");
    look(20'h00012, 3'd2, 1'b0); expect_miss("R7 flush all");
    do_fill(20'h00777, 3'd6, 1'b0);
    expect_miss("R10 unrelated fill");
    look(20'h00777, 3'd6, 1'b0); expect_hit("R10 after refill", 20'h00777);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_wprot();
    t_fill_plru();
    t_same_cycle();
    t_refresh();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule